// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block decides when a small CPU bus controller inserts DRAM refresh cycles. A timer runs on every CPU clock state and expires at an interval chosen by a 2-bit field in a control register. Each expiry raises a pending refresh request. The request is granted only at a machine-cycle boundary signalled by the core. It is held off during wait states, bus release and sleep.

A granted refresh lasts a fixed three clocks. For those clocks the block drives a refresh strobe and a busy flag, so that the core stretches its next access, and it presents an 8-bit row address. The row address advances after each completed refresh.

Two cases need care. When the bus is handed away, the timer keeps running but expiries are dropped. When the CPU sleeps, expiries are latched into a single pending request, which is served at the first machine-cycle boundary after sleep ends.

Top module: `refresh_sched`

## Requirements
- R1: The interval field (`cfg_wdata_i[1:0]`, loaded when `cfg_we_i` is high, read back on `cfg_rdata_o`) sets the timer period: code 0 gives 10 clocks, 1 gives 20, 2 gives 40 and 3 gives 80.
- R2: Reset behaviour:
  - During reset the field is 0, the row counter is 0, and `rfsh_o` and `busy_o` are low.
  - The timer restarts from zero at reset.
  - With `mc_end_i` held high, the first refresh strobe appears in the 11th clock after reset is released.
- R3: Each refresh keeps `rfsh_o` and `busy_o` both high for exactly 3 consecutive clocks.
- R4: A refresh starts in the clock after an edge at which all of the following hold:
  - a request is pending;
  - `mc_end_i` is high;
  - `wait_i`, `bus_rel_i` and `sleep_i` are low;
  - no refresh is running.
- R5: While `bus_rel_i` is high, no refresh starts, the pending request is dropped, and expiries are discarded. The timer keeps counting.
- R6: During `sleep_i`, expiries are latched. Several expiries collapse into one pending request, which starts at the first `mc_end_i` after sleep ends.
- R7: While `wait_i` is high, a pending request is held and does not start.
- R8: `row_o` is stable during a refresh. It increments by one, wrapping modulo 256, at the clock where a refresh completes.
- R9: A newly written interval takes effect only when the timer next restarts.
- R10: An expiry that occurs during a running refresh stays pending and is served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 2 | New interval code |
| cfg_rdata_o | output | 2 | Current interval code |
| mc_end_i | input | 1 | Machine-cycle boundary from the core |
| wait_i | input | 1 | Core is in a wait state |
| bus_rel_i | input | 1 | Bus released to an external master |
| sleep_i | input | 1 | CPU in sleep mode |
| rfsh_o | output | 1 | Refresh strobe |
| busy_o | output | 1 | Refresh occupies the bus; core stretches |
| row_o | output | 8 | Refresh row address |

## Verification
A timer that miscounts shows up at once as a refresh strobe that starts a clock early or late relative to the 10/20/40/80 spacing. A pending flag that is lost or not cleared shows up as a missing refresh after sleep, or as an extra one after bus release, within one interval. A sequencer or row-counter fault changes the strobe width or the `row_o` value on the very clock after the refresh in question. Every output is compared with a cycle model on every clock, so each fault is caught at its first visible clock.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  function automatic int unsigned interval_len(input logic [1:0] code, input int unsigned base);
    return base << code;
  endfunction
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer import refsched_pkg::*; #(
  parameter int unsigned BASE  = 10,
  parameter int unsigned CFG_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] code_i,
  output logic             tick_o
);
  localparam int unsigned MAX_LEN = BASE << ((1 << CFG_W) - 1);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CFG_W-1:0] cur_q;
  logic             last;

  assign last   = (32'(cnt_q) == interval_len(cur_q, BASE) - 1);
  assign tick_o = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else if (last) begin
      cnt_q <= '0;
      cur_q <= code_i; // new code applies at restart
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < interval_len(cur_q, BASE));
  p_code_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(cur_q));
endmodule

// File: rtl/refresh_seq.sv
module refresh_seq #(
  parameter int unsigned REF_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic mc_end_i,
  input  logic wait_i,
  input  logic bus_rel_i,
  input  logic sleep_i,
  output logic act_o,
  output logic done_o
);
  localparam int unsigned PH_W = (REF_LEN > 1) ? $clog2(REF_LEN) : 1;

  logic            pend_q, act_q, start;
  logic [PH_W-1:0] ph_q;

  assign start  = pend_q && mc_end_i && !wait_i && !bus_rel_i && !sleep_i && !act_q;
  assign done_o = act_q && (ph_q == PH_W'(REF_LEN - 1));
  assign act_o  = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (bus_rel_i) pend_q <= 1'b0;  // expiries dropped while bus is away
    else if (tick_i)    pend_q <= 1'b1;  // sleep latch: newest replaces older
    else if (start)     pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      ph_q  <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      ph_q  <= '0;
    end else if (done_o) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      ph_q <= ph_q + PH_W'(1);
    end
  end

  p_start_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(mc_end_i && !wait_i && !bus_rel_i && !sleep_i));
  p_no_start_bus_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rel_i && !act_q) |=> !act_q);
  p_no_start_sleep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !act_q) |=> !act_q);
  p_no_start_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && !act_q) |=> !act_q);
  p_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !done_o) |=> act_q);
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             done_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (done_i) row_q <= row_q + ROW_W'(1);
  end

  assign row_o = row_q;

  p_row_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_i) |-> row_q == $past(row_q) + ROW_W'(1));
  p_row_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && $past(act_i)) |-> $stable(row_q));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned BASE    = 10,
  parameter int unsigned CFG_W   = 2,
  parameter int unsigned REF_LEN = 3,
  parameter int unsigned ROW_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             mc_end_i,
  input  logic             wait_i,
  input  logic             bus_rel_i,
  input  logic             sleep_i,
  output logic             rfsh_o,
  output logic             busy_o,
  output logic [ROW_W-1:0] row_o
);
  logic [CFG_W-1:0] code_q;
  logic             tick, act, done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       code_q <= '0;
    else if (cfg_we_i) code_q <= cfg_wdata_i;
  end

  refresh_timer #(.BASE(BASE), .CFG_W(CFG_W)) u_timer (
    .clk_i, .rst_ni, .code_i(code_q), .tick_o(tick)
  );

  refresh_seq #(.REF_LEN(REF_LEN)) u_seq (
    .clk_i, .rst_ni, .tick_i(tick), .mc_end_i, .wait_i, .bus_rel_i, .sleep_i,
    .act_o(act), .done_o(done)
  );

  refresh_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i, .rst_ni, .act_i(act), .done_i(done), .row_o
  );

  assign cfg_rdata_o = code_q;
  assign rfsh_o      = act;
  assign busy_o      = act;

  p_busy_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_o == busy_o);
  p_reset_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> code_q == '0);
endmodule

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_wdata = 2'd0;
  logic [1:0] cfg_rdata;
  logic       mc_end = 1'b0, wt = 1'b0, brel = 1'b0, slp = 1'b0;
  logic       rfsh, busy;
  logic [7:0] row;

  int n_chk = 0, n_fail = 0;
  bit chk_en = 1'b0;
  string cur_tag = "R2";

  always #10 clk = ~clk;

  refresh_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .mc_end_i(mc_end), .wait_i(wt), .bus_rel_i(brel),
    .sleep_i(slp), .rfsh_o(rfsh), .busy_o(busy), .row_o(row)
  );

  // cycle model built from the requirements
  function automatic int exp_len(input logic [1:0] c);
    case (c)
      2'd0: return 10;
      2'd1: return 20;
      2'd2: return 40;
      default: return 80;
    endcase
  endfunction

  int m_cnt, m_ph;
  logic [1:0] m_code, m_cur;
  bit m_pend, m_act;
  logic [7:0] m_row;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_code = 0; m_cur = 0; m_pend = 0; m_act = 0; m_row = 0;
    end else begin
      bit tick, start, done;
      tick  = (m_cnt == exp_len(m_cur) - 1);
      start = m_pend && mc_end && !wt && !brel && !slp && !m_act;
      done  = m_act && (m_ph == 2);
      if (tick) begin m_cnt = 0; m_cur = m_code; end else m_cnt++;
      if (brel) m_pend = 0; else if (tick) m_pend = 1; else if (start) m_pend = 0;
      if (start) begin m_act = 1; m_ph = 0; end
      else if (done) begin m_act = 0; m_row = m_row + 8'd1; end
      else if (m_act) m_ph++;
      if (cfg_we) m_code = cfg_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_en) begin
    check(rfsh == m_act, {cur_tag, " rfsh R3"}, rfsh, m_act);
    check(busy == m_act, {cur_tag, " busy R3"}, busy, m_act);
    check(row == m_row, {cur_tag, " row R8"}, row, m_row);
    check(cfg_rdata == m_code, {cur_tag, " cfg R1"}, cfg_rdata, m_code);
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(rfsh == 0 && busy == 0, "R2 strobes in reset", rfsh, 0);
    check(row == 0, "R2 row in reset", row, 0);
    check(cfg_rdata == 0, "R2 code in reset", cfg_rdata, 0);
    rst_n = 1'b1;
  endtask

  task automatic wr_code(input logic [1:0] c);
    cfg_we = 1'b1; cfg_wdata = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // clocks from now until the next rising refresh strobe
  task automatic to_rise(output int n);
    bit prev;
    n = 0; prev = rfsh;
    forever begin
      @(negedge clk); n++;
      if (rfsh && !prev) break;
      prev = rfsh;
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int n, hi;
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();
    chk_en = 1'b1;
    mc_end = 1'b1;
    cur_tag = "R2";
    to_rise(n);
    check(n == 11, "R2 first refresh delay", n, 11);
    to_rise(n);
    check(n == 10, "R1 code 0 spacing", n, 10);
    // strobe width
    hi = 1;
    while (rfsh) begin @(negedge clk); if (rfsh) hi++; end
    check(hi == 3, "R3 refresh width", hi, 3);

    cur_tag = "R9";
    wr_code(2'd3);
    to_rise(n);
    to_rise(n);
    check(n == 80, "R1 code 3 spacing", n, 80);
    wr_code(2'd1);
    to_rise(n);
    to_rise(n);
    check(n == 20, "R1 code 1 spacing", n, 20);
    wr_code(2'd2);
    to_rise(n);
    to_rise(n);
    check(n == 40, "R1 code 2 spacing", n, 40);
    wr_code(2'd0);
    to_rise(n);

    cur_tag = "R5";
    brel = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (i > 3) check(!rfsh, "R5 no refresh in bus release", rfsh, 0);
    end
    brel = 1'b0;

    cur_tag = "R6";
    slp = 1'b1;
    for (int i = 0; i < 35; i++) begin
      @(negedge clk);
      if (i > 3) check(!rfsh, "R6 no refresh in sleep", rfsh, 0);
    end
    slp = 1'b0;
    @(negedge clk);
    check(rfsh == 1, "R6 latched request served at first boundary", rfsh, 1);
    repeat (4) @(negedge clk);

    cur_tag = "R7";
    wt = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (i > 3) check(!rfsh, "R7 held during wait", rfsh, 0);
    end
    wt = 1'b0;
    @(negedge clk);
    check(rfsh == 1, "R7 served after wait", rfsh, 1);

    cur_tag = "R8";
    repeat (2700) @(negedge clk);

    cur_tag = "R4 R10";
    for (int i = 0; i < 20000; i++) begin
      mc_end = ($urandom_range(0, 9) < 4);
      wt     = ($urandom_range(0, 9) < 2);
      if ($urandom_range(0, 199) == 0) brel = ~brel;
      if ($urandom_range(0, 149) == 0) slp = ~slp;
      if ($urandom_range(0, 299) == 0) begin
        cfg_we = 1'b1; cfg_wdata = 2'($urandom_range(0, 3));
      end else cfg_we = 1'b0;
      @(negedge clk);
    end
    cfg_we = 1'b0;

    cur_tag = "R2";
    chk_en = 1'b0;
    do_reset();
    chk_en = 1'b1;
    repeat (20) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule